// File: doc/BRIEF.md
# Keyed Watchdog Timer with Write-Once Mode

This block is a watchdog timer for a system that must prove it is alive by writing a fixed key byte at regular intervals. A counter advances on each cycle in which the clock-enable `tick` input is high. When it reaches the selected period without having been restarted, the block issues a one-cycle reset request to the system reset controller. The block has a byte-wide register bus with two registers: a mode register and a key register.

The mode register can be written once after reset. It sets the overflow period and can stop the watchdog for good. Before it is written, the watchdog runs with its longest period. The key register restarts the count only when it receives the exact key byte as a whole-byte write. A wrong key, a bit-wise write, or a second write to the mode register is treated as a sign of runaway software and also raises the reset request. When software has locked the watchdog in the stopped state, all of those access errors are ignored.

The bus has a write strobe, a read strobe, an address, 8-bit write data, and a qualifier that marks a write as a bit-manipulation access. Read data is registered.

Top module: `keyed_wdog`

## Requirements
- R1: A whole-byte write of 0xAC to the key address (address 1) does not raise `rst_req`. It also returns the counter to zero, so the next overflow comes a full period of ticks after that write.
- R2: A whole-byte write of any value other than 0xAC to the key address sets `rst_req` high in the cycle after the write edge, unless the watchdog is locked stopped.
- R3: A write to the key address with `wr_bitop` high sets `rst_req` high in the cycle after the write, whatever the data, unless the watchdog is locked stopped.
- R4: A read of the key address returns 0x9A in `rdata` in the cycle after `rd_en`. A read of the mode address (address 0) returns the stored mode byte. After reset the key register reads 0x9A.
- R5: Only the first mode write after reset is accepted. A later mode write raises `rst_req` in the next cycle, unless the watchdog is locked stopped, and leaves the stored mode byte unchanged.
- R6: A mode write with `wr_bitop` high raises `rst_req` in the next cycle, unless the watchdog is already locked stopped. It leaves the mode byte unchanged and still uses up the single allowed mode write.
- R7: An accepted mode byte with bit 4 set locks the watchdog stopped. Bit 3 has no effect. While locked, the counter does not advance and no access or overflow raises `rst_req`.
- R8: Mode bits 2..0 (sel) set the period to 2^(BASE_LOG2+sel) ticks. The counter advances only on cycles with `tick` high. Overflow while running raises `rst_req` and starts a new period.
- R9: From reset until the first mode write, the mode byte reads 0x07 and the watchdog runs with the longest period, sel = 7.
- R10: `rst_req` is a registered signal and is low during and right after reset. A single violation or overflow makes it high for exactly one cycle. `rdata` resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| tick | input | 1 | Count enable for the watchdog counter |
| wr_en | input | 1 | Write strobe |
| wr_bitop | input | 1 | Marks the current write as a bit-manipulation access |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address: 0 selects mode, 1 selects key |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
Faults in the write-once flag or in the stopped lock show up on `rst_req` one cycle after the next mode or key access. Either a pulse appears where none is expected, or an expected pulse is missing. A wrong period decode or a counter that fails to clear shows up only when the period ends, as an overflow pulse that arrives too early or too late. The bench therefore measures the exact number of edges to each overflow for several values of sel, with continuous and gated ticks. A stored mode byte that has been corrupted is visible in the next mode read.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam logic [7:0] RESTART_KEY  = 8'hAC;
  localparam logic [7:0] KEY_READ_VAL = 8'h9A;
  localparam logic [7:0] MODE_DEFAULT = 8'h07;
  localparam int unsigned STOP_BIT    = 4;
  localparam int unsigned SEL_W       = 3;

  typedef struct packed {
    logic       mode_wr;
    logic       key_wr;
    logic       bitop;
    logic [7:0] data;
  } wdog_wr_t;
endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 2'd0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 2'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bitop,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        mode_byte,
  output logic              locked_stop,
  output logic              restart,
  output logic              viol,
  output logic [7:0]        rdata
);
  wdog_wr_t   acc;
  logic       written_q, written_d;
  logic [7:0] mode_q, mode_d;
  logic [7:0] rdata_q, rdata_d;
  logic       rd_load;

  always_comb begin
    acc.mode_wr = wr_en && (addr == MODE_ADDR);
    acc.key_wr  = wr_en && (addr == KEY_ADDR);
    acc.bitop   = wr_bitop;
    acc.data    = wdata;
  end

  // Stopped lock: a whole-byte first write with the stop bit set.
  assign locked_stop = written_q && mode_q[STOP_BIT];

  // Next state of the write-once mode register
  always_comb begin
    written_d = written_q | acc.mode_wr;
    mode_d    = mode_q;
    if (acc.mode_wr && !written_q && !acc.bitop) begin
      mode_d = acc.data;
    end
  end

  // Access checks
  always_comb begin
    viol    = 1'b0;
    restart = acc.key_wr && !acc.bitop && (acc.data == RESTART_KEY);
    if (!locked_stop) begin
      if (acc.mode_wr && (written_q || acc.bitop)) begin
        viol = 1'b1;
      end
      if (acc.key_wr && (acc.bitop || (acc.data != RESTART_KEY))) begin
        viol = 1'b1;
      end
    end
  end

  // Read data select
  assign rd_load = rd_en;
  always_comb begin
    rdata_d = rdata_q;
    if (rd_load) begin
      if (addr == MODE_ADDR) begin
        rdata_d = mode_q;
      end else if (addr == KEY_ADDR) begin
        rdata_d = KEY_READ_VAL;
      end else begin
        rdata_d = 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written_q <= 1'b0;
      mode_q    <= MODE_DEFAULT;
      rdata_q   <= 8'h00;
    end else begin
      written_q <= written_d;
      mode_q    <= mode_d;
      rdata_q   <= rdata_d;
    end
  end

  assign mode_byte = mode_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/keyed_wdog_cnt.sv
module keyed_wdog_cnt
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             ovf
);
  localparam int unsigned NSEL  = 1 << SEL_W;
  localparam int unsigned CNT_W = BASE_LOG2 + NSEL - 1;

  logic [CNT_W-1:0] term_tab [NSEL];
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Terminal count for each period selection: 2^(BASE_LOG2+g) - 1
  for (genvar g = 0; g < NSEL; g++) begin : g_term
    assign term_tab[g] = CNT_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
  end

  assign term   = term_tab[sel];
  assign cnt_en = run && tick;

  always_comb begin
    cnt_d = cnt_q;
    ovf   = 1'b0;
    if (clear) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      if (cnt_q >= term) begin
        cnt_d = '0;
        ovf   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 2'd0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 2'd1,
  parameter int unsigned BASE_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              wr_bitop,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rst_req
);
  logic [7:0] mode_byte;
  logic       locked_stop;
  logic       restart;
  logic       viol;
  logic       ovf;
  logic       req_q, req_d;

  keyed_wdog_regs #(
    .ADDR_W   (ADDR_W),
    .MODE_ADDR(MODE_ADDR),
    .KEY_ADDR (KEY_ADDR)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_bitop   (wr_bitop),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .mode_byte  (mode_byte),
    .locked_stop(locked_stop),
    .restart    (restart),
    .viol       (viol),
    .rdata      (rdata)
  );

  keyed_wdog_cnt #(
    .BASE_LOG2(BASE_LOG2)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .run  (!locked_stop),
    .clear(restart),
    .sel  (mode_byte[SEL_W-1:0]),
    .ovf  (ovf)
  );

  assign req_d = viol | ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign rst_req = req_q;
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 2'd0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 2'd1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_bitop,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              rst_req,
  input logic              locked_stop
);
  p_good_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == KEY_ADDR && !wr_bitop && wdata == 8'hAC) |=> !rst_req);

  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == KEY_ADDR && !wr_bitop && wdata != 8'hAC && !locked_stop) |=> rst_req);

  p_bitop_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == KEY_ADDR && wr_bitop && !locked_stop) |=> rst_req);

  p_key_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == KEY_ADDR) |=> (rdata == 8'h9A));

  p_bitop_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == MODE_ADDR && wr_bitop && !locked_stop) |=> rst_req);

  p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked_stop |=> !rst_req);

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked_stop |=> locked_stop);
endmodule

bind keyed_wdog keyed_wdog_chk #(
  .ADDR_W   (ADDR_W),
  .MODE_ADDR(MODE_ADDR),
  .KEY_ADDR (KEY_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_bitop   (wr_bitop),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .rst_req    (rst_req),
  .locked_stop(locked_stop)
);

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
  localparam int BASE = 4;
  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_KEY  = 2'd1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_bitop = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rst_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_wdog #(.BASE_LOG2(BASE)) u_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_bitop(wr_bitop),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  task automatic check(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_bitop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Write in one cycle; returns at the next negedge, where rst_req shows that edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic bop);
    addr = a; wdata = d; wr_bitop = bop; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_bitop = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // Ticks every cycle; returns the number of edges until rst_req is seen
  task automatic measure(input int max, output int edges);
    edges = -1;
    tick = 1'b1;
    for (int k = 1; k <= max && edges < 0; k++) begin
      @(negedge clk);
      if (rst_req) edges = k;
    end
    tick = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    do_reset();
    check("R10 rst_req low after reset", int'(rst_req), 0);
    check("R10 rdata reset value", int'(rdata), 8'h00);
    rd(A_KEY, d);
    check("R4 key reads 0x9A after reset", int'(d), 8'h9A);
    rd(A_MODE, d);
    check("R9 default mode byte", int'(d), 8'h07);
    check("R4 read raises no request", int'(rst_req), 0);
  endtask

  task automatic t_default_period();
    int e;
    do_reset();
    measure(3000, e);
    check("R9 default period 2^(BASE+7) ticks", e, 1 << (BASE + 7));
    @(negedge clk);
    check("R10 overflow pulse one cycle wide", int'(rst_req), 0);
  endtask

  task automatic t_restart();
    int e;
    logic [7:0] d;
    do_reset();
    wr(A_MODE, 8'h00, 1'b0);
    check("R1 first mode write accepted quietly", int'(rst_req), 0);
    rd(A_MODE, d);
    check("R8 mode byte stored", int'(d), 8'h00);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    wr(A_KEY, 8'hAC, 1'b0);
    check("R1 correct key raises no request", int'(rst_req), 0);
    measure(200, e);
    check("R1 full period after restart (sel 0)", e, 1 << BASE);
    @(negedge clk);
    check("R10 pulse ends", int'(rst_req), 0);
    measure(200, e);
    check("R8 next period after overflow", e, 1 << BASE);
  endtask

  task automatic t_tick_gate();
    int e;
    do_reset();
    wr(A_MODE, 8'h02, 1'b0);
    wr(A_KEY, 8'hAC, 1'b0);
    e = -1;
    for (int k = 1; k <= 400 && e < 0; k++) begin
      tick = (k % 2 == 1);
      @(negedge clk);
      if (rst_req) e = k;
    end
    tick = 1'b0;
    // 64 ticks on odd edges: the 64th falls on edge 127
    check("R8 counts only on tick (sel 2, half-rate)", e, 127);
  endtask

  task automatic t_bad_key();
    do_reset();
    wr(A_KEY, 8'h55, 1'b0);
    check("R2 wrong key 0x55 raises request", int'(rst_req), 1);
    @(negedge clk);
    check("R10 violation pulse one cycle wide", int'(rst_req), 0);
    wr(A_KEY, 8'hAD, 1'b0);
    check("R2 wrong key 0xAD raises request", int'(rst_req), 1);
  endtask

  task automatic t_bitop_key();
    do_reset();
    wr(A_KEY, 8'hAC, 1'b1);
    check("R3 bit-op key write raises request", int'(rst_req), 1);
  endtask

  task automatic t_second_mode();
    logic [7:0] d;
    do_reset();
    wr(A_MODE, 8'h01, 1'b0);
    check("R5 first mode write quiet", int'(rst_req), 0);
    wr(A_MODE, 8'h05, 1'b0);
    check("R5 second mode write raises request", int'(rst_req), 1);
    rd(A_MODE, d);
    check("R5 mode byte unchanged", int'(d), 8'h01);
  endtask

  task automatic t_bitop_mode();
    logic [7:0] d;
    do_reset();
    wr(A_MODE, 8'h10, 1'b1);
    check("R6 bit-op mode write raises request", int'(rst_req), 1);
    rd(A_MODE, d);
    check("R6 mode byte unchanged", int'(d), 8'h07);
    wr(A_MODE, 8'h10, 1'b0);
    check("R6 bit-op used up the single write", int'(rst_req), 1);
  endtask

  task automatic t_stopped();
    logic [7:0] d;
    int seen;
    do_reset();
    wr(A_MODE, 8'h18, 1'b0);
    check("R7 stop write quiet", int'(rst_req), 0);
    seen = 0;
    tick = 1'b1;
    for (int k = 0; k < 2200; k++) begin
      @(negedge clk);
      if (rst_req) seen++;
    end
    tick = 1'b0;
    check("R7 no overflow while stopped", seen, 0);
    wr(A_KEY, 8'h33, 1'b0);
    check("R7 wrong key ignored when stopped", int'(rst_req), 0);
    wr(A_KEY, 8'hAC, 1'b1);
    check("R7 bit-op key ignored when stopped", int'(rst_req), 0);
    wr(A_MODE, 8'h00, 1'b0);
    check("R7 second mode write ignored when stopped", int'(rst_req), 0);
    rd(A_MODE, d);
    check("R7 mode stays stopped (bit 3 ignored)", int'(d), 8'h18);
  endtask

  initial begin
    t_reset_state();
    t_default_period();
    t_restart();
    t_tick_gate();
    t_bad_key();
    t_bitop_key();
    t_second_mode();
    t_bitop_mode();
    t_stopped();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog timeout: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule